// File: doc/BRIEF.md
# Power-Up and Host-Reset Bring-Up Sequencer

This block orders the bring-up of a network interface device. It starts when its supply rails come up and runs again each time the host lets go of its fundamental reset. It first qualifies the oscillator and holds the device's internal reset until the rails and the clock have settled. It then asks the configuration loader for a first read of the non-volatile store. The bits returned by that read decide whether wake-up and manageability start enabled.

When the host releases its reset, the sequencer asks for a second read and holds the PHY in power-down until that read completes. It also clears wake enable. Three cycle counters, started by the release, open link training, the acceptance of configuration accesses and the sending of configuration responses. A host write that sets the memory-access-enable command bit moves the device power state from uninitialised-active to active. Re-asserting host reset withdraws everything the release granted. Losing any rail returns the whole block to powered-down.

Top module: `bringup_seq`

## Requirements
- R1: Once every `supply_ok` bit is 1 and `osc_in` is 1, `int_rst_n` rises on the (T_XOG+T_PPG+1)-th rising clock edge. The first edge that samples the last of these inputs counts as edge 1. While `osc_in` is 0, `int_rst_n` stays 0. If `osc_in` rises after the T_XOG qualification has already run out, the release comes on edge T_PPG+1.
- R2: In the cycle after any `supply_ok` bit is sampled 0, the outputs take their powered-down values: `int_rst_n`=0, `phy_pd`=1, `wake_en`=0, `mng_en`=0, `link_train`=`cfg_accept`=`cfg_resp_ok`=0 and `pwr_state`=0. The same values apply after the block reset `rst_n`.
- R3: `nvm_req` is a pulse one cycle wide. It rises in the same cycle as `int_rst_n`.
- R4: A first-load `nvm_done`, sampled while that load is outstanding, sets `phy_pd` to 0, `wake_en` to `nvm_wake_bit` and `mng_en` to `nvm_mng_bit`, all in the next cycle.
- R5: An `nvm_done` that arrives while no load is outstanding changes no output.
- R6: `host_rst_n` is sampled 1 after the first load is done. In the next cycle `nvm_req` pulses, `phy_pd` goes to 1 and `wake_en` goes to 0. If the host reset is already released while the first load is outstanding, this response waits until the cycle after that load's completion has taken effect.
- R7: The `nvm_done` of the second load sets `phy_pd` to 0 in the next cycle. `mng_en` keeps its value.
- R8: `link_train` rises on edge T_TRN+1, counted from the edge that samples the host release as edge 1.
- R9: `cfg_accept` rises on edge T_CFG+1 and `cfg_resp_ok` rises on edge T_RES+1, both counted the same way as in R8. T_CFG must not exceed T_RES, which is checked at elaboration.
- R10: `pwr_state` encodes 0 as powered-down, 1 as D0u and 2 as D0a. A write with `mae_wr`=1 and `mae_data`=1, sampled while the host reset is released, gives 2 in the next cycle. A write with `mae_data`=0, or a write made while the host reset is asserted, leaves the value at 1.
- R11: Host reset is sampled 0 after a release. In the next cycle `link_train`, `cfg_accept` and `cfg_resp_ok` are 0 and `pwr_state` is 1. Host reset has priority over a second-load done sampled on the same edge. A new release restarts the second load and all three delays from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | N_SUP | One good flag per supply rail |
| osc_in | input | 1 | Oscillator running indication |
| host_rst_n | input | 1 | Host fundamental reset, active low |
| nvm_done | input | 1 | Completion pulse from the configuration loader |
| nvm_wake_bit | input | 1 | Wake-up enable bit returned by a load |
| nvm_mng_bit | input | 1 | Manageability enable bit returned by a load |
| mae_wr | input | 1 | Host write strobe for the command register |
| mae_data | input | 1 | Memory-access-enable bit of that write |
| int_rst_n | output | 1 | Internal device reset, active low |
| nvm_req | output | 1 | Single-cycle load request |
| phy_pd | output | 1 | PHY power-down |
| wake_en | output | 1 | Wake-up enable |
| mng_en | output | 1 | Manageability enable |
| link_train | output | 1 | Link training may start |
| cfg_accept | output | 1 | Configuration accesses may be accepted |
| cfg_resp_ok | output | 1 | Configuration responses may be sent |
| pwr_state | output | 2 | Device power state: 0 powered-down, 1 D0u, 2 D0a |

## Verification
The bench aborts the host release at random points inside the delay windows. A design whose counters did not restart would then raise link training early on the next release. The bench also lands the second-load done on the same edge as the re-asserted host reset, where giving the done priority would wrongly bring the PHY up. Stray done pulses and releases that arrive before the first load completes are aimed at a design that trusts every done or starts the second load too early: such a design would overwrite the wake bits or pulse the load request twice. Memory-access-enable writes carrying a 0, or made under host reset, catch a power state that moves without the real command.

// File: rtl/bringup_pkg.sv
// Shared types of the bring-up sequencer.
// Assumes: nothing; pure type definitions.
package bringup_pkg;

    // Device power state as seen on the pwr_state port.
    typedef enum logic [1:0] {
        PWR_OFF = 2'd0,
        PWR_D0U = 2'd1,
        PWR_D0A = 2'd2
    } pwr_state_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        SQ_OFF   = 3'd0,
        SQ_LOAD1 = 3'd1,
        SQ_AUX   = 3'd2,
        SQ_LOAD2 = 3'd3,
        SQ_UP    = 3'd4
    } seq_state_e;

    // Number of delays started by the host reset release.
    localparam int unsigned N_HOST_DLY = 3;

endpackage

// File: rtl/bringup_timer.sv
// Enable-qualified down-counter delay.
// While en is low the counter is held at DELAY. While en is high it counts
// down once per clock and stops at zero. expired is high while en is high
// and the count has reached zero.
// Assumes: DELAY fits in 32 bits; DELAY = 0 gives immediate expiry.
module bringup_timer #(
    parameter int unsigned DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int unsigned W    = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [W-1:0] LOAD = W'(DELAY);

    logic [W-1:0] cnt;

    // Reload while idle, count down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expiry is only meaningful while the timer runs.
    always_comb begin
        expired = en && (cnt == '0);
    end

    // Once expired, the timer stays expired until its enable drops (R8).
    p_expiry_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && expired) |=> (expired || !en));

endmodule

// File: rtl/bringup_por.sv
// Power-on qualification.
// Waits T_XOG cycles of good supplies before trusting the oscillator, then
// T_PPG cycles of a running oscillator before reporting ready. Any supply
// loss restarts both delays.
// Assumes: supply and oscillator flags are synchronous to clk.
module bringup_por #(
    parameter int unsigned N_SUP = 3,
    parameter int unsigned T_XOG = 20,
    parameter int unsigned T_PPG = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SUP-1:0] supply_ok,
    input  logic             osc_in,
    output logic             sup_good,
    output logic             por_ready
);
    logic xog_done;
    logic ppg_en;

    // All rails must report good together.
    always_comb begin
        sup_good = &supply_ok;
        ppg_en   = sup_good && xog_done && osc_in;
    end

    bringup_timer #(.DELAY(T_XOG)) u_xog (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sup_good),
        .expired (xog_done)
    );

    bringup_timer #(.DELAY(T_PPG)) u_ppg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ppg_en),
        .expired (por_ready)
    );

    // Readiness never appears without good supplies and a running clock (R1).
    p_ready_needs_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_ready |-> (osc_in && sup_good));

endmodule

// File: rtl/bringup_ctrl.sv
// Bring-up state machine.
// Orders the two configuration loads, PHY power-down, wake and manageability
// enables and the device power state. Host reset re-assertion returns to the
// pre-release phase; supply loss returns to powered-down.
// Assumes: nvm_done is a single-cycle pulse; host_rst_n is synchronous.
module bringup_ctrl
    import bringup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_good,
    input  logic       por_ready,
    input  logic       host_rst_n,
    input  logic       nvm_done,
    input  logic       nvm_wake_bit,
    input  logic       nvm_mng_bit,
    input  logic       mae_wr,
    input  logic       mae_data,
    output logic       int_rst_n,
    output logic       nvm_req,
    output logic       phy_pd,
    output logic       wake_en,
    output logic       mng_en,
    output logic       host_up,
    output logic [1:0] pwr_state
);
    seq_state_e state;
    logic       d0a;

    // Phase sequencing and the registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_good) begin
            state   <= SQ_OFF;
            nvm_req <= 1'b0;
            phy_pd  <= 1'b1;
            wake_en <= 1'b0;
            mng_en  <= 1'b0;
        end else begin
            nvm_req <= 1'b0;
            unique case (state)
                SQ_OFF: begin
                    if (por_ready) begin
                        state   <= SQ_LOAD1;
                        nvm_req <= 1'b1;
                    end
                end
                SQ_LOAD1: begin
                    if (nvm_done) begin
                        state   <= SQ_AUX;
                        phy_pd  <= 1'b0;
                        wake_en <= nvm_wake_bit;
                        mng_en  <= nvm_mng_bit;
                    end
                end
                SQ_AUX: begin
                    if (host_rst_n) begin
                        state   <= SQ_LOAD2;
                        nvm_req <= 1'b1;
                        phy_pd  <= 1'b1;
                        wake_en <= 1'b0;
                    end
                end
                SQ_LOAD2: begin
                    if (!host_rst_n) begin
                        state <= SQ_AUX;
                    end else if (nvm_done) begin
                        state  <= SQ_UP;
                        phy_pd <= 1'b0;
                    end
                end
                SQ_UP: begin
                    if (!host_rst_n) begin
                        state <= SQ_AUX;
                    end
                end
                default: state <= SQ_OFF;
            endcase
        end
    end

    // Memory-access-enable latch, cleared whenever the host reset is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_good || !host_up) begin
            d0a <= 1'b0;
        end else if (mae_wr && mae_data) begin
            d0a <= 1'b1;
        end
    end

    // Derived reset, host phase and power state.
    always_comb begin
        int_rst_n = (state != SQ_OFF);
        host_up   = (state == SQ_LOAD2) || (state == SQ_UP);
        if (state == SQ_OFF) begin
            pwr_state = PWR_OFF;
        end else if (host_up && d0a) begin
            pwr_state = PWR_D0A;
        end else begin
            pwr_state = PWR_D0U;
        end
    end

    // Load request lasts exactly one cycle (R3).
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_req |=> !nvm_req);

    // Supply loss forces the powered-down outputs next cycle (R2).
    p_supply_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_good |=> (!int_rst_n && phy_pd && !wake_en && !mng_en));

    // Host release from the pre-release phase reloads and parks the PHY (R6).
    p_release_parks_phy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_AUX && host_rst_n && sup_good) |=> (nvm_req && phy_pd && !wake_en));

    // Active power state exists only while the host reset is released (R10).
    p_d0a_needs_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_D0A) |-> host_up);

endmodule

// File: rtl/bringup_seq.sv
// Top of the bring-up sequencer.
// Combines power-on qualification, the bring-up state machine and the three
// delays started by the host reset release (link training, configuration
// accept, configuration response).
// Assumes: all inputs synchronous to clk; delays given in clk cycles.
module bringup_seq #(
    parameter int unsigned N_SUP = 3,
    parameter int unsigned T_XOG = 20,
    parameter int unsigned T_PPG = 10,
    parameter int unsigned T_TRN = 40,
    parameter int unsigned T_CFG = 60,
    parameter int unsigned T_RES = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SUP-1:0] supply_ok,
    input  logic             osc_in,
    input  logic             host_rst_n,
    input  logic             nvm_done,
    input  logic             nvm_wake_bit,
    input  logic             nvm_mng_bit,
    input  logic             mae_wr,
    input  logic             mae_data,
    output logic             int_rst_n,
    output logic             nvm_req,
    output logic             phy_pd,
    output logic             wake_en,
    output logic             mng_en,
    output logic             link_train,
    output logic             cfg_accept,
    output logic             cfg_resp_ok,
    output logic [1:0]       pwr_state
);
    import bringup_pkg::*;

    // Delay for host-release timer i: 0 training, 1 accept, 2 response.
    function automatic int unsigned host_delay(int idx);
        case (idx)
            0:       return T_TRN;
            1:       return T_CFG;
            default: return T_RES;
        endcase
    endfunction

    if (T_CFG > T_RES) begin : g_order_bad
        $error("bringup_seq: T_CFG must not exceed T_RES");
    end

    logic                  sup_good;
    logic                  por_ready;
    logic                  host_up;
    logic [N_HOST_DLY-1:0] host_exp;

    bringup_por #(.N_SUP(N_SUP), .T_XOG(T_XOG), .T_PPG(T_PPG)) u_por (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .osc_in    (osc_in),
        .sup_good  (sup_good),
        .por_ready (por_ready)
    );

    bringup_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sup_good     (sup_good),
        .por_ready    (por_ready),
        .host_rst_n   (host_rst_n),
        .nvm_done     (nvm_done),
        .nvm_wake_bit (nvm_wake_bit),
        .nvm_mng_bit  (nvm_mng_bit),
        .mae_wr       (mae_wr),
        .mae_data     (mae_data),
        .int_rst_n    (int_rst_n),
        .nvm_req      (nvm_req),
        .phy_pd       (phy_pd),
        .wake_en      (wake_en),
        .mng_en       (mng_en),
        .host_up      (host_up),
        .pwr_state    (pwr_state)
    );

    for (genvar i = 0; i < N_HOST_DLY; i++) begin : g_host_dly
        bringup_timer #(.DELAY(host_delay(i))) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (host_up),
            .expired (host_exp[i])
        );
    end

    // Host-release grants come straight from their timers.
    always_comb begin
        link_train  = host_exp[0];
        cfg_accept  = host_exp[1];
        cfg_resp_ok = host_exp[2];
    end

    // A response permit never precedes the access accept (R9).
    p_resp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_resp_ok |-> cfg_accept);

    // Host reset re-assertion withdraws every release grant (R11).
    p_abort_withdraws_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_up && !host_rst_n) |=>
            (!link_train && !cfg_accept && !cfg_resp_ok && pwr_state != 2'd2));

endmodule

// File: tb/bringup_seq_test.sv
module bringup_seq_test;
    localparam int N_SUP = 3;
    localparam int T_XOG = 20;
    localparam int T_PPG = 10;
    localparam int T_TRN = 40;
    localparam int T_CFG = 60;
    localparam int T_RES = 90;
    localparam int WIN   = T_RES + 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_SUP-1:0] supply_ok;
    logic             osc_in, host_rst_n, nvm_done, nvm_wake_bit, nvm_mng_bit;
    logic             mae_wr, mae_data;
    logic             int_rst_n, nvm_req, phy_pd, wake_en, mng_en;
    logic             link_train, cfg_accept, cfg_resp_ok;
    logic [1:0]       pwr_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bringup_seq #(.N_SUP(N_SUP), .T_XOG(T_XOG), .T_PPG(T_PPG),
                  .T_TRN(T_TRN), .T_CFG(T_CFG), .T_RES(T_RES)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .osc_in(osc_in),
        .host_rst_n(host_rst_n), .nvm_done(nvm_done), .nvm_wake_bit(nvm_wake_bit),
        .nvm_mng_bit(nvm_mng_bit), .mae_wr(mae_wr), .mae_data(mae_data),
        .int_rst_n(int_rst_n), .nvm_req(nvm_req), .phy_pd(phy_pd),
        .wake_en(wake_en), .mng_en(mng_en), .link_train(link_train),
        .cfg_accept(cfg_accept), .cfg_resp_ok(cfg_resp_ok), .pwr_state(pwr_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected grant of a host-release timer k edges after the release.
    function automatic int e_grant(int k, int d, int ab);
        return (k >= d + 1 && (ab == 0 || k <= ab)) ? 1 : 0;
    endfunction

    // Expected PHY power-down during the host-release window.
    function automatic int e_pd(int k, int ld, int ab);
        bit eff = (ab == 0) || (ld < ab);
        return (eff && k >= ld + 1) ? 0 : 1;
    endfunction

    // Expected power state during the host-release window.
    function automatic int e_pwr(int k, int mk, int md, int ab);
        return (md == 1 && k >= mk + 1 && (ab == 0 || k <= ab)) ? 2 : 1;
    endfunction

    task automatic check_off(input string tag);
        chk({tag, " R2 int_rst_n"}, int'(int_rst_n), 0);
        chk({tag, " R2 phy_pd"}, int'(phy_pd), 1);
        chk({tag, " R2 wake/mng"}, int'({wake_en, mng_en}), 0);
        chk({tag, " R2 grants"}, int'({link_train, cfg_accept, cfg_resp_ok}), 0);
        chk({tag, " R2 pwr_state"}, int'(pwr_state), 0);
    endtask

    task automatic wait_release(output int k);
        k = 0;
        while (!int_rst_n && k < 1000) begin
            tick();
            k++;
        end
    endtask

    task automatic pulse_done(input bit w, input bit m);
        nvm_wake_bit = w;
        nvm_mng_bit  = m;
        nvm_done     = 1'b1;
        tick();
        nvm_done     = 1'b0;
    endtask

    // Host release window with optional abort at edge ab (0 = none).
    task automatic host_window(input int ab, input int exp_mng);
        int ld = $urandom_range(1, WIN - 5);
        int mk = $urandom_range(1, WIN - 5);
        int md = $urandom_range(0, 1);
        host_rst_n = 1'b1;
        for (int k = 1; k <= WIN; k++) begin
            tick();
            chk("R6 nvm_req pulse", int'(nvm_req), (k == 1) ? 1 : 0);
            chk("R6 wake cleared", int'(wake_en), 0);
            chk("R7 phy_pd", int'(phy_pd), e_pd(k, ld, ab));
            chk("R7 mng kept", int'(mng_en), exp_mng);
            chk("R8 link_train", int'(link_train), e_grant(k, T_TRN, ab));
            chk("R9 cfg_accept", int'(cfg_accept), e_grant(k, T_CFG, ab));
            chk("R9 cfg_resp_ok", int'(cfg_resp_ok), e_grant(k, T_RES, ab));
            chk("R10 R11 pwr_state", int'(pwr_state), e_pwr(k, mk, md, ab));
            nvm_done = (k == ld);
            mae_wr   = (k == mk);
            mae_data = md[0];
            if (k == ab) host_rst_n = 1'b0;
        end
        nvm_done = 1'b0;
        mae_wr   = 1'b0;
    endtask

    initial begin
        int k;
        void'($urandom(32'd7321));
        rst_n = 1'b0; supply_ok = '0; osc_in = 1'b0; host_rst_n = 1'b0;
        nvm_done = 1'b0; nvm_wake_bit = 1'b0; nvm_mng_bit = 1'b0;
        mae_wr = 1'b0; mae_data = 1'b0;
        repeat (3) tick();
        check_off("reset");
        chk("R3 reset nvm_req", int'(nvm_req), 0);
        rst_n = 1'b1;

        // R1: oscillator held low blocks release; release T_PPG+1 after it rises.
        supply_ok = '1;
        repeat (T_XOG + T_PPG + 20) tick();
        chk("R1 held by osc", int'(int_rst_n), 0);
        osc_in = 1'b1;
        wait_release(k);
        chk("R1 release after osc", k, T_PPG + 1);
        chk("R3 req with release", int'(nvm_req), 1);
        chk("R4 pd during load1", int'(phy_pd), 1);
        tick();
        chk("R3 req one cycle", int'(nvm_req), 0);

        // R4 then R5: first done applies bits, a stray done does nothing.
        pulse_done(1'b1, 1'b0);
        chk("R4 phy up", int'(phy_pd), 0);
        chk("R4 wake bit", int'(wake_en), 1);
        chk("R4 mng bit", int'(mng_en), 0);
        pulse_done(1'b0, 1'b1);
        tick();
        chk("R5 wake unchanged", int'(wake_en), 1);
        chk("R5 mng unchanged", int'(mng_en), 0);
        chk("R5 no request", int'(nvm_req), 0);

        // R10: enable write under host reset is ignored.
        mae_wr = 1'b1; mae_data = 1'b1;
        tick();
        mae_wr = 1'b0;
        tick();
        chk("R10 write under reset", int'(pwr_state), 1);

        // R6: release parks PHY and clears wake.
        host_rst_n = 1'b1;
        tick();
        chk("R6 req", int'(nvm_req), 1);
        chk("R6 pd", int'(phy_pd), 1);
        chk("R6 wake", int'(wake_en), 0);

        // R2: a single rail drop powers everything down.
        supply_ok[1] = 1'b0;
        tick();
        check_off("rail drop");
        host_rst_n = 1'b1;
        supply_ok = '1;
        wait_release(k);
        chk("R1 full delay", k, T_XOG + T_PPG + 1);

        // R6 deferral: host already released during load 1.
        repeat (5) tick();
        chk("R6 no early req", int'(nvm_req), 0);
        chk("R6 pd while load1", int'(phy_pd), 1);
        pulse_done(1'b1, 1'b1);
        chk("R4 bits before reload", int'({phy_pd, wake_en, mng_en}), 3);
        tick();
        chk("R6 deferred req", int'(nvm_req), 1);
        chk("R6 deferred pd", int'(phy_pd), 1);
        chk("R6 deferred wake", int'(wake_en), 0);

        // Random full sequences with aborts and stray dones.
        for (int it = 0; it < 10; it++) begin
            int ab;
            bit wb, mb;
            host_rst_n = 1'b0;
            supply_ok = N_SUP'($urandom_range(0, (1 << N_SUP) - 2));
            tick();
            check_off("random");
            repeat ($urandom_range(0, 4)) tick();
            supply_ok = '1;
            wait_release(k);
            chk("R1 random release", k, T_XOG + T_PPG + 1);
            repeat ($urandom_range(1, 25)) tick();
            wb = 1'($urandom_range(0, 1));
            mb = 1'($urandom_range(0, 1));
            pulse_done(wb, mb);
            chk("R4 random wake", int'(wake_en), int'(wb));
            chk("R4 random mng", int'(mng_en), int'(mb));
            if ($urandom_range(0, 1) == 1) begin
                pulse_done(~wb, ~mb);
                chk("R5 random stray", int'({wake_en, mng_en, nvm_req}), int'({wb, mb, 1'b0}));
            end
            repeat ($urandom_range(0, 6)) tick();
            ab = (it % 3 == 2) ? 0 : $urandom_range(1, T_RES + 2);
            if (it == 1) ab = T_TRN;
            host_window(ab, int'(mb));
            if (ab != 0) begin
                host_rst_n = 1'b0;
                repeat ($urandom_range(1, 5)) tick();
                host_window(0, int'(mb)); // R11 restart from zero
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule